// File: doc/BRIEF.md
# Cascadable Serial Result Output Stage

This block is the digital output side of a sampling converter that can be cascaded with identical parts on a shared serial clock. It keeps the most recent conversion word, optionally followed by an 8-bit channel tag, and sends it out on a serial data line MSB first while the select input is low. A configuration bit picks the position of the device in a cascade. The head device appends zeros after its own word. Every device further down the chain feeds the bits from its chain input in behind its own word. As a result, the words of upstream devices come out of the last device one after another, each one a fixed number of serial clocks later.

The serial clock, select and chain input are sampled by a fast system clock. Edges of the serial clock are therefore detected inside the block, and the serial output and its enable are both driven from registers. The analog conversion is modelled as a data word, a channel number and a valid strobe.

Top module: `ser_chain_out`

## Requirements
- R1: `sdo_oe` is 0 in every cycle that follows a cycle with `cs_n` high, and it is 1 in every cycle that follows a cycle with `cs_n` low (one register stage).
- R2: The held result and channel are loaded only when `conv_valid` is 1 while `cs_n` is high. A strobe while `cs_n` is low has no effect, and the next frame still sends the earlier word.
- R3: One clock after `cs_n` falls, `sdo` shows bit DATA_W-1 of the held result. The remaining bits follow MSB first. `sdo` changes only on the clock after a falling edge of `sclk` is sampled, and holds steady at all other times.
- R4: When `cfg_head` is 1 (head of chain), `cdi` is ignored and zeros are shifted out after the local word (or after the tag).
- R5: When `cfg_head` is 0 and the tag is off, the `cdi` bit captured at the n-th rising edge of `sclk` is driven on `sdo` as serial bit n+16 of the frame, which is a pass-through delay of 16 serial clocks.
- R6: When `cfg_tag_en` is 1, the 16-bit word is followed by an 8-bit tag made of the 3-bit channel (MSB first) and then five zeros. In chain mode the pass-through delay becomes 24 serial clocks.
- R7: `cfg_head` and `cfg_tag_en` are sampled when `cs_n` falls. Changes to them during a frame have no effect until the next frame.
- R8: After reset, `sdo_oe` and `sdo` are 0 and the held result is zero, so a frame read with no prior strobe sends 16 zero bits.
- R9: Raising `cs_n` in the middle of a frame ends it. The next falling edge of `cs_n` starts again with the local word from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial signals |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; a frame lasts while it is low |
| sclk | input | 1 | Serial clock; input is captured on its rise, output shifts on its fall |
| cdi | input | 1 | Serial data from the upstream device |
| conv_data | input | 16 | Conversion result word |
| conv_valid | input | 1 | Strobe marking conv_data and conv_chan as new |
| conv_chan | input | 3 | Channel number the result belongs to |
| cfg_head | input | 1 | 1 = head of chain (zeros follow), 0 = pass chain input through |
| cfg_tag_en | input | 1 | 1 = append the 8-bit channel tag after the word |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | Output enable for sdo; 0 means the line is released |

## Verification
A shift register that has lost its alignment shows up within the first 16 serial bits. The local word comes out rotated, or the upstream word starts at the wrong bit. An insertion point set to the wrong position moves the upstream data by 8 bits, and that shows in the first frame run in chain mode. A stale frame configuration or a missed cleanup on abort becomes visible at the first bit after the next falling edge of select. The bench drives upstream patterns with distinct bit values, so that any shift of one bit or more changes the word it reads back.

// File: rtl/ser_chain_pkg.sv
package ser_chain_pkg;

  // Position of the device in a cascade; the encoding is the config bit value.
  typedef enum logic {
    CHAIN_PASS = 1'b0,
    CHAIN_HEAD = 1'b1
  } chain_pos_e;

  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_TAG_W  = 8;
  localparam int unsigned DEF_CHAN_W = 3;

endpackage

// File: rtl/sc_edge_track.sv
module sc_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_fall
);

  logic sclk_q;
  logic cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_n_q <= cs_n;
    end
  end

  // Serial edges only count inside a frame.
  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;
  assign sel_fall  = ~cs_n & cs_n_q;

endmodule

// File: rtl/sc_result_hold.sv
module sc_result_hold #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHAN_W-1:0] chan_in,
  output logic [DATA_W-1:0] data_q,
  output logic [CHAN_W-1:0] chan_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      chan_q <= '0;
    end else if (load_en) begin
      data_q <= data_in;
      chan_q <= chan_in;
    end
  end

endmodule

// File: rtl/sc_out_shifter.sv
module sc_out_shifter
  import ser_chain_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              bit_capture,
  input  logic              bit_shift,
  input  logic              cdi,
  input  logic [DATA_W-1:0] word,
  input  logic [CHAN_W-1:0] chan,
  input  chain_pos_e        pos_in,
  input  logic              tag_in,
  output logic              sdo
);

  localparam int unsigned SR_W = DATA_W + TAG_W;

  logic [SR_W-1:0]  sr_q;
  logic [SR_W-1:0]  sr_next;
  logic [TAG_W-1:0] tag_word;
  logic             cdi_cap_q;
  chain_pos_e       pos_f;
  logic             tag_f;
  logic             fill;

  // Tag: channel number at the top, zero padding below.
  generate
    if (TAG_W > CHAN_W) begin : g_tag_pad
      assign tag_word = {chan, {(TAG_W-CHAN_W){1'b0}}};
    end else begin : g_tag_trunc
      assign tag_word = chan[CHAN_W-1 -: TAG_W];
    end
  endgenerate

  // The new bit enters at the bottom of the active window, so the pass-through
  // delay equals the window length (DATA_W or DATA_W+TAG_W).
  always_comb begin
    fill    = (pos_f == CHAIN_HEAD) ? 1'b0 : cdi_cap_q;
    sr_next = sr_q << 1;
    if (tag_f) sr_next[0]     = fill;
    else       sr_next[TAG_W] = fill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= '0;
      cdi_cap_q <= 1'b0;
      pos_f     <= CHAIN_HEAD;
      tag_f     <= 1'b0;
    end else begin
      if (frame_start) begin
        pos_f     <= pos_in;
        tag_f     <= tag_in;
        cdi_cap_q <= 1'b0;
        sr_q      <= tag_in ? {word, tag_word} : {word, {TAG_W{1'b0}}};
      end else begin
        if (bit_capture) cdi_cap_q <= cdi;
        if (bit_shift)   sr_q      <= sr_next;
      end
    end
  end

  assign sdo = sr_q[SR_W-1];

endmodule

// File: rtl/ser_chain_out.sv
module ser_chain_out
  import ser_chain_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned TAG_W  = DEF_TAG_W,
  parameter int unsigned CHAN_W = DEF_CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              cdi,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_valid,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              cfg_head,
  input  logic              cfg_tag_en,
  output logic              sdo,
  output logic              sdo_oe
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              sel_fall;
  logic [DATA_W-1:0] held_data;
  logic [CHAN_W-1:0] held_chan;
  logic              oe_q;
  chain_pos_e        pos_cfg;

  assign pos_cfg = chain_pos_e'(cfg_head);

  sc_edge_track u_edges (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sel_fall  (sel_fall)
  );

  sc_result_hold #(
    .DATA_W (DATA_W),
    .CHAN_W (CHAN_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_en (conv_valid & cs_n),
    .data_in (conv_data),
    .chan_in (conv_chan),
    .data_q  (held_data),
    .chan_q  (held_chan)
  );

  sc_out_shifter #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .CHAN_W (CHAN_W)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .frame_start (sel_fall),
    .bit_capture (sclk_rise),
    .bit_shift   (sclk_fall),
    .cdi         (cdi),
    .word        (held_data),
    .chan        (held_chan),
    .pos_in      (pos_cfg),
    .tag_in      (cfg_tag_en),
    .sdo         (sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~cs_n;
  end

  assign sdo_oe = oe_q;

endmodule

// File: rtl/sc_chain_checker.sv
module sc_chain_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [DATA_W-1:0] held_data
);

  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)               age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: released line after a deselected cycle
  p_release_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && $past(cs_n)) |-> !sdo_oe);

  // R1: driven line after a selected cycle
  p_drive_when_selected_r1: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && !$past(cs_n)) |-> sdo_oe);

  // R2: the held word cannot change during a frame
  p_hold_frozen_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (age_q != 2'd0 && !$past(cs_n)) |-> $stable(held_data));

  // R3: sdo moves only after a sampled sclk fall
  p_sdo_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && sdo_oe && $past(sdo_oe) &&
     !($past(sclk, 2) && !$past(sclk))) |-> $stable(sdo));

  // R8: reset leaves the output released and low
  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (!sdo_oe && !sdo));

endmodule

bind ser_chain_out sc_chain_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .held_data (held_data)
);

// File: tb/sim_ser_chain_out.sv
module sim_ser_chain_out;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        cdi = 1'b0;
  logic [15:0] conv_data = '0;
  logic        conv_valid = 1'b0;
  logic [2:0]  conv_chan = '0;
  logic        cfg_head = 1'b1;
  logic        cfg_tag_en = 1'b0;
  logic        sdo;
  logic        sdo_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ser_chain_out u0 (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .cdi        (cdi),
    .conv_data  (conv_data),
    .conv_valid (conv_valid),
    .conv_chan  (conv_chan),
    .cfg_head   (cfg_head),
    .cfg_tag_en (cfg_tag_en),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic load_result(input logic [15:0] d, input logic [2:0] ch);
    @(negedge clk);
    conv_data = d; conv_chan = ch; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  // Runs one frame of nbits serial clocks; flip_at toggles cfg_head before that bit.
  task automatic run_frame(input int nbits, input logic [63:0] din, input int flip_at,
                           input bit close, output logic [63:0] dout);
    dout = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == flip_at) cfg_head = ~cfg_head;
      dout[nbits-1-i] = sdo;
      cdi = din[nbits-1-i];
      @(negedge clk) sclk = 1'b1;
      @(negedge clk);
      @(negedge clk) sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    if (close) begin
      cs_n = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [63:0] r;
    chk("R8 oe after reset", {63'b0, sdo_oe}, 64'd0);
    chk("R8 sdo after reset", {63'b0, sdo}, 64'd0);
    run_frame(16, 64'hFFFF, -1, 1'b1, r);
    chk("R8 zero word after reset", r, 64'd0);
  endtask

  task automatic t_enable();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 oe while selected", {63'b0, sdo_oe}, 64'd1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe after deselect", {63'b0, sdo_oe}, 64'd0);
  endtask

  task automatic t_msb_first();
    logic [63:0] r;
    load_result(16'h0001, 3'd0);
    run_frame(16, 64'h0, -1, 1'b1, r);
    chk("R3 msb first 0001", r, 64'h0001);
    load_result(16'hA5C3, 3'd5);
    run_frame(16, 64'h0, -1, 1'b1, r);
    chk("R3 own word A5C3", r, 64'hA5C3);
  endtask

  task automatic t_head_mode();
    logic [63:0] r;
    cfg_head = 1'b1; cfg_tag_en = 1'b0;
    run_frame(32, 64'hFFFF_FFFF, -1, 1'b1, r);
    chk("R4 head mode ignores cdi", r, 64'hA5C3_0000);
  endtask

  task automatic t_pass_mode();
    logic [63:0] r;
    cfg_head = 1'b0; cfg_tag_en = 1'b0;
    run_frame(32, 64'h1234_5678, -1, 1'b1, r);
    chk("R5 one upstream word", r, 64'hA5C3_1234);
    run_frame(48, 64'h1234_9ABC_0000, -1, 1'b1, r);
    chk("R5 two upstream words", r, 64'hA5C3_1234_9ABC);
    cfg_head = 1'b1;
  endtask

  task automatic t_tag();
    logic [63:0] r;
    cfg_tag_en = 1'b1; cfg_head = 1'b1;
    run_frame(32, 64'hFFFF_FFFF, -1, 1'b1, r);
    chk("R6 tag head mode", r, 64'hA5C3_A000);
    cfg_head = 1'b0;
    run_frame(40, 64'hBEEF_0000_00, -1, 1'b1, r);
    chk("R6 tag pass delay 24", r, 64'hA5C3_A0BE_EF);
    cfg_head = 1'b1; cfg_tag_en = 1'b0;
  endtask

  task automatic t_cfg_latch();
    logic [63:0] r;
    cfg_head = 1'b1; cfg_tag_en = 1'b0;
    run_frame(32, 64'hFFFF_FFFF, 3, 1'b1, r);
    chk("R7 mid-frame mode change", r, 64'hA5C3_0000);
    cfg_head = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) cfg_tag_en = 1'b1;
    run_frame(24, 64'h0, -1, 1'b1, r);
    chk("R7 tag change held until next frame", r[23:0], 64'hA5C3_00);
    cfg_tag_en = 1'b0;
  endtask

  task automatic t_load_rule();
    logic [63:0] r;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    conv_data = 16'h3C3C; conv_valid = 1'b1;
    @(negedge clk) conv_valid = 1'b0;
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(16, 64'h0, -1, 1'b1, r);
    chk("R2 strobe during frame ignored", r, 64'hA5C3);
    load_result(16'h3C3C, 3'd2);
    run_frame(16, 64'h0, -1, 1'b1, r);
    chk("R2 strobe while idle loads", r, 64'h3C3C);
  endtask

  task automatic t_abort();
    logic [63:0] r;
    load_result(16'h8E71, 3'd1);
    run_frame(5, 64'h0, -1, 1'b1, r);
    chk("R9 partial frame bits", r[4:0], 64'h11);
    run_frame(16, 64'h0, -1, 1'b1, r);
    chk("R9 restart after abort", r, 64'h8E71);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_msb_first();
    t_head_mode();
    t_pass_mode();
    t_tag();
    t_cfg_latch();
    t_load_rule();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule